// File: doc/BRIEF.md
# Successive-Approximation Converter Bus Controller

This block is the digital half of a bus-attached successive-approximation converter. It decodes five processor-side control pins: chip enable, active-low chip select, read/convert, a word/byte read mode and a single address bit. From them it starts a conversion, raises a busy flag, and walks a successive-approximation register from the most significant bit downward. It resolves one bit per clock from a single comparator decision input. The trial code for the external DAC is an output, so a comparator model closes the loop.

A conversion begins when chip enable is high, chip select is low and read/convert is low at the same time. Whichever of the three reaches its active level last starts it. At that moment the address bit picks a full-length or a short cycle. Once busy falls, a read presents the result in one of two ways. It can be one full word, or two left-justified bytes on the upper eight bus lanes, with the address bit choosing the byte. The bus is modelled as a data vector plus a per-lane output enable. Lanes that are not enabled float to Z.

The processor side is a plain pin interface with no valid/ready pair and no back-pressure. The busy flag is the only flow control. Software polls it and must not read or expect a fresh start until it is low.

Top module: `sar_bus_ctrl`

## Requirements
- R1: While chip_en is low or chip_sel_n is high, no conversion starts, busy stays low and no bus lane is enabled.
- R2: A conversion starts on the clock edge where the start term (chip_en high, chip_sel_n low, rd_conv low) first becomes true. Any of the three inputs, or all together, may make that transition. A start term held true after a conversion ends does not launch another one.
- R3: addr0 sampled at start selects the cycle length: 0 gives a 12-bit cycle with busy high for 12 clocks, 1 gives an 8-bit cycle with busy high for 8 clocks. wide_rd has no influence on the start or the length.
- R4: busy rises on the clock edge that accepts a start, and is high only while a conversion is running.
- R5: While busy is high, bus_oe is all zeros and bus_data is all Z, even with a read condition present.
- R6: A new start edge during busy does not restart the conversion. The running sequence keeps its position, but addr0 is re-latched, so a 12-bit cycle switched to 8-bit ends after 8 clocks in total.
- R7: dac_code during busy is the bits decided so far plus a 1 at the bit under trial. The first trial is 0x800. The comparator input cmp_hi = 1 means the input is at or above the trial code and keeps the bit, so the result is the largest code not above the input.
- R8: After an 8-bit cycle, result bits [3:0] are zero.
- R9: A read (chip_en high, chip_sel_n low, rd_conv high, busy low) with wide_rd = 1 enables all 12 lanes and drives the full result.
- R10: A read with wide_rd = 0 enables only lanes [11:4], and lanes [3:0] float. With addr0 = 0 it drives result[11:4] there. With addr0 = 1 it drives {result[3:0], 4'b0000} there.
- R11: The result stays unchanged while busy is low, including through ignored control activity, until the next conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one SAR bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable, active high |
| chip_sel_n | input | 1 | Chip select, active low |
| rd_conv | input | 1 | High = read, low = convert |
| wide_rd | input | 1 | High = full-word read, low = byte read |
| addr0 | input | 1 | Cycle length at start; byte select at read |
| cmp_hi | input | 1 | Comparator decision: input at or above dac_code |
| dac_code | output | 12 | Trial code for the external DAC |
| busy | output | 1 | Conversion in progress |
| bus_data | output | 12 | Data bus; Z on lanes not enabled |
| bus_oe | output | 12 | Per-lane output enable |

## Verification
Conversions are launched four ways: with read/convert, chip enable or chip select as the last input to arrive, and with all three arriving together. This separates a correct last-arrival detector from one that watches a single pin. Input values at both ends of the range and mid-scale patterns with mixed bits separate a correct MSB-first keep/drop decision from a wrong bit order. Each conversion is run in both cycle lengths and read in all three read layouts, which shows whether lane placement and the zeroed low nibble are right. A mid-conversion re-start with a changed address bit, plus pin activity with the chip disabled or deselected, show that restarts and idle activity leave the sequence and the held result alone.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_WORD = 2'd1,
    RD_HIGH = 2'd2,
    RD_LOW  = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/sar_ctl_decode.sv
module sar_ctl_decode
  import sar_ctl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    chip_en,
  input  logic    chip_sel_n,
  input  logic    rd_conv,
  input  logic    wide_rd,
  input  logic    addr0,
  input  logic    busy,
  output logic    start_pulse,
  output rd_sel_e rd_sel
);
  logic start_term;
  logic start_q;
  logic rd_term;

  // all three start inputs active together; the last arrival makes the edge
  assign start_term = chip_en & ~chip_sel_n & ~rd_conv;
  assign rd_term    = chip_en & ~chip_sel_n &  rd_conv & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_term;
  end

  assign start_pulse = start_term & ~start_q;

  always_comb begin
    if (!rd_term)     rd_sel = RD_NONE;
    else if (wide_rd) rd_sel = RD_WORD;
    else if (addr0)   rd_sel = RD_LOW;
    else              rd_sel = RD_HIGH;
  end

  // R2: a held start term gives one pulse only
  a_r2_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
endmodule

// File: rtl/sar_ctl_engine.sv
module sar_ctl_engine #(
  parameter int WIDTH   = 12,
  parameter int SHORT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_pulse,
  input  logic             addr0,
  input  logic             cmp_hi,
  output logic             busy,
  output logic [WIDTH-1:0] dac_code,
  output logic [WIDTH-1:0] result
);
  localparam int IW  = $clog2(WIDTH);
  localparam int LOW = WIDTH - SHORT_W;
  localparam logic [IW-1:0] TOP_I = IW'(WIDTH - 1);
  localparam logic [IW-1:0] LOW_I = IW'(LOW);

  logic             busy_q;
  logic             short_q;
  logic [IW-1:0]    idx_q;
  logic [WIDTH-1:0] work_q;
  logic [WIDTH-1:0] res_q;
  logic [WIDTH-1:0] next_work;
  logic [WIDTH-1:0] final_word;
  logic [WIDTH-1:0] trial_bit;
  logic             last;

  // a short cycle ends at the lowest kept bit, or at once if re-latched below it
  assign last = short_q ? (idx_q <= LOW_I) : (idx_q == '0);

  always_comb begin
    trial_bit        = '0;
    trial_bit[idx_q] = 1'b1;
    next_work        = work_q;
    next_work[idx_q] = cmp_hi;
    final_word       = next_work;
    if (short_q) final_word[LOW-1:0] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      short_q <= 1'b0;
      idx_q   <= '0;
      work_q  <= '0;
      res_q   <= '0;
    end else if (busy_q) begin
      work_q <= next_work;
      if (start_pulse) short_q <= addr0;  // restart ignored, length re-latched
      if (last) begin
        busy_q <= 1'b0;
        res_q  <= final_word;
      end else begin
        idx_q <= idx_q - 1'b1;
      end
    end else if (start_pulse) begin
      busy_q  <= 1'b1;
      short_q <= addr0;
      idx_q   <= TOP_I;
      work_q  <= '0;
    end
  end

  assign busy     = busy_q;
  assign dac_code = busy_q ? (work_q | trial_bit) : '0;
  assign result   = res_q;

  // R6: a start during a running cycle keeps stepping, no restart
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_pulse && !last) |=> (busy_q && idx_q == $past(idx_q) - 1'b1));
  // R4: a new conversion begins from the top bit with nothing decided
  a_r4_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (idx_q == TOP_I && work_q == '0));
  // R8: short cycles leave the low bits clear
  a_r8_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && $past(short_q)) |-> (res_q[LOW-1:0] == '0));
  // R11: result only changes at the end of a conversion
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> $stable(res_q));
endmodule

// File: rtl/sar_ctl_drive.sv
module sar_ctl_drive
  import sar_ctl_pkg::*;
#(
  parameter int WIDTH   = 12,
  parameter int SHORT_W = 8
) (
  input  rd_sel_e          rd_sel,
  input  logic [WIDTH-1:0] result,
  output logic [WIDTH-1:0] lane_val,
  output logic [WIDTH-1:0] lane_oe
);
  localparam int LOW = WIDTH - SHORT_W;
  localparam int PAD = SHORT_W - LOW;

  always_comb begin
    lane_val = '0;
    lane_oe  = '0;
    unique case (rd_sel)
      RD_WORD: begin
        lane_val = result;
        lane_oe  = '1;
      end
      RD_HIGH: begin
        lane_val[WIDTH-1 -: SHORT_W] = result[WIDTH-1 -: SHORT_W];
        lane_oe[WIDTH-1 -: SHORT_W]  = '1;
      end
      RD_LOW: begin
        lane_val[WIDTH-1 -: SHORT_W] = {result[LOW-1:0], {PAD{1'b0}}};
        lane_oe[WIDTH-1 -: SHORT_W]  = '1;
      end
      default: begin
        lane_val = '0;
        lane_oe  = '0;
      end
    endcase
  end
endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl
  import sar_ctl_pkg::*;
#(
  parameter int WIDTH   = 12,
  parameter int SHORT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en,
  input  logic             chip_sel_n,
  input  logic             rd_conv,
  input  logic             wide_rd,
  input  logic             addr0,
  input  logic             cmp_hi,
  output logic [WIDTH-1:0] dac_code,
  output logic             busy,
  output logic [WIDTH-1:0] bus_data,
  output logic [WIDTH-1:0] bus_oe
);
  logic             start_pulse;
  rd_sel_e          rd_sel;
  logic [WIDTH-1:0] result;
  logic [WIDTH-1:0] lane_val;

  sar_ctl_decode u_decode (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_en     (chip_en),
    .chip_sel_n  (chip_sel_n),
    .rd_conv     (rd_conv),
    .wide_rd     (wide_rd),
    .addr0       (addr0),
    .busy        (busy),
    .start_pulse (start_pulse),
    .rd_sel      (rd_sel)
  );

  sar_ctl_engine #(.WIDTH(WIDTH), .SHORT_W(SHORT_W)) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_pulse (start_pulse),
    .addr0       (addr0),
    .cmp_hi      (cmp_hi),
    .busy        (busy),
    .dac_code    (dac_code),
    .result      (result)
  );

  sar_ctl_drive #(.WIDTH(WIDTH), .SHORT_W(SHORT_W)) u_drive (
    .rd_sel   (rd_sel),
    .result   (result),
    .lane_val (lane_val),
    .lane_oe  (bus_oe)
  );

  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    assign bus_data[g] = bus_oe[g] ? lane_val[g] : 1'bz;
  end

  // R5: nothing reaches the bus while converting
  a_r5_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bus_oe == '0));
  // R1: a disabled or deselected chip never begins a conversion
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((!chip_en || chip_sel_n) && !busy) |=> !busy);
endmodule

// File: tb/tb_sar_bus_ctrl.sv
`timescale 1ns/1ps
module tb_sar_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_en = 1'b0;
  logic        chip_sel_n = 1'b1;
  logic        rd_conv = 1'b1;
  logic        wide_rd = 1'b1;
  logic        addr0 = 1'b0;
  logic [11:0] analog = 12'h000;
  logic        cmp_hi;
  wire  [11:0] dac_code;
  wire         busy;
  wire  [11:0] bus_data;
  wire  [11:0] bus_oe;

  int checks = 0;
  int fails = 0;
  bit ended = 1'b0;

  typedef struct { int cyc; string tag; } exp_t;
  exp_t exp_q[$];
  int busy_cnt = 0;

  always #2.5 clk = ~clk;

  assign cmp_hi = (analog >= dac_code);

  sar_bus_ctrl dut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .chip_sel_n(chip_sel_n),
    .rd_conv(rd_conv), .wide_rd(wide_rd), .addr0(addr0), .cmp_hi(cmp_hi),
    .dac_code(dac_code), .busy(busy), .bus_data(bus_data), .bus_oe(bus_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // monitor: measures busy length and compares it with the scoreboard entry
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cnt++;
      else if (busy_cnt != 0) begin
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected conversion", 12'(busy_cnt), 12'd0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(busy_cnt == e.cyc, e.tag, 12'(busy_cnt), 12'(e.cyc));
        end
        busy_cnt = 0;
      end
    end
  end

  // sel: 0 rd_conv last, 1 chip_en last, 2 chip_sel_n last, 3 all together
  task automatic convert(input logic [11:0] val, input logic a0, input int sel, input logic wide);
    exp_t e;
    @(negedge clk);
    analog = val; addr0 = a0; wide_rd = wide;
    chip_en = (sel != 1) && (sel != 3);
    chip_sel_n = (sel == 2) || (sel == 3);
    rd_conv = (sel == 0) || (sel == 3);
    @(negedge clk);
    chk(busy == 1'b0, "R2 no start before last input", 12'(busy), 12'd0);
    e.cyc = a0 ? 8 : 12;
    e.tag = a0 ? "R3 short cycle length" : "R3 full cycle length";
    exp_q.push_back(e);
    chip_en = 1'b1; chip_sel_n = 1'b0; rd_conv = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R4 busy on start edge", 12'(busy), 12'd1);
    chk(dac_code == 12'h800, "R7 first trial code", dac_code, 12'h800);
    @(negedge clk);
    chk(dac_code == ({val[11], 11'b0} | 12'h400), "R7 second trial code",
        dac_code, {val[11], 11'b0} | 12'h400);
    do @(negedge clk); while (busy);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R2 held start term no retrigger", 12'(busy), 12'd0);
    chip_en = 1'b0; rd_conv = 1'b1; chip_sel_n = 1'b1;
  endtask

  task automatic read_all(input logic [11:0] res, input string tag);
    @(negedge clk);
    chip_en = 1'b1; chip_sel_n = 1'b0; rd_conv = 1'b1; wide_rd = 1'b1; addr0 = 1'b0;
    #1;
    chk(bus_data === res && bus_oe === 12'hFFF, {"R9 word read ", tag}, bus_data, res);
    @(negedge clk);
    wide_rd = 1'b0; addr0 = 1'b0;
    #1;
    chk(bus_data === {res[11:4], 4'bzzzz} && bus_oe === 12'hFF0,
        {"R10 high byte ", tag}, bus_data, {res[11:4], 4'bzzzz});
    @(negedge clk);
    addr0 = 1'b1;
    #1;
    chk(bus_data === {res[3:0], 4'b0000, 4'bzzzz} && bus_oe === 12'hFF0,
        {"R10 low byte ", tag}, bus_data, {res[3:0], 4'b0000, 4'bzzzz});
    @(negedge clk);
    chip_en = 1'b0; rd_conv = 1'b1; chip_sel_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog expired", 12'd0, 12'd1);
    finish_run();
  end

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && bus_oe == 12'h000 && dac_code == 12'h000,
        "R4 reset state", {busy, bus_oe[10:0]}, 12'h000);
    rst_n = 1'b1;
    @(negedge clk);

    convert(12'hA5C, 1'b0, 0, 1'b0);
    read_all(12'hA5C, "R7 mid pattern");
    convert(12'h7F3, 1'b1, 1, 1'b0);
    read_all(12'h7F0, "R8 short zero low");
    convert(12'hFFF, 1'b0, 2, 1'b1);
    read_all(12'hFFF, "R7 top of range");
    convert(12'h000, 1'b1, 3, 1'b1);
    read_all(12'h000, "R7 bottom of range");
    convert(12'h35A, 1'b0, 3, 1'b1);
    read_all(12'h35A, "R2 simultaneous");

    // R1: activity while disabled or deselected
    @(negedge clk);
    analog = 12'hC3C;
    chip_en = 1'b0; chip_sel_n = 1'b0; rd_conv = 1'b1;
    @(negedge clk); rd_conv = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 chip_en low no start", 12'(busy), 12'd0);
    chip_en = 1'b1; chip_sel_n = 1'b1; rd_conv = 1'b1;
    @(negedge clk); rd_conv = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 deselected no start", 12'(busy), 12'd0);
    rd_conv = 1'b1; wide_rd = 1'b1;
    #1;
    chk(bus_oe === 12'h000 && bus_data === 12'hzzz, "R1 deselected no drive", bus_oe, 12'h000);
    @(negedge clk);
    chip_en = 1'b0; chip_sel_n = 1'b0;
    #1;
    chk(bus_oe === 12'h000, "R1 disabled no drive", bus_oe, 12'h000);
    chip_sel_n = 1'b1;
    read_all(12'h35A, "R11 held after idle activity");

    // R6: restart during busy re-latches length only; R5 read blocked
    @(negedge clk);
    analog = 12'h9AB; addr0 = 1'b0; wide_rd = 1'b1;
    chip_en = 1'b1; chip_sel_n = 1'b0; rd_conv = 1'b1;
    @(negedge clk);
    e.cyc = 8; e.tag = "R6 relatched length";
    exp_q.push_back(e);
    rd_conv = 1'b0;
    repeat (3) @(negedge clk);
    rd_conv = 1'b1;
    #1;
    chk(bus_oe === 12'h000 && bus_data === 12'hzzz, "R5 no read while busy", bus_oe, 12'h000);
    @(negedge clk);
    chk(busy == 1'b1, "R5 still busy", 12'(busy), 12'd1);
    addr0 = 1'b1; rd_conv = 1'b0;
    do @(negedge clk); while (busy);
    chip_en = 1'b0; rd_conv = 1'b1; chip_sel_n = 1'b1;
    read_all(12'h9A0, "R6 relatched result");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all conversions seen", 12'(exp_q.size()), 12'd0);
    finish_run();
  end
endmodule